// File: doc/BRIEF.md
# Speed-Scaled Iteration Timer

This block is a programmable down-counting timer whose unit of time is one "iteration" of fixed length, tied to the Ethernet media-independent interface link speed. Software loads a 16-bit iteration count. The timer then counts down once per iteration and raises a single-cycle expiry pulse when the count runs out. The remaining count can be read back at any time.

The iteration clock comes from `mii_ce`, a one-cycle enable that pulses at the fast-link nibble-clock rate. One iteration is 2^`PRESCALE_W` such enables (2048 by default, 81.92 us at 25 MHz) when the link runs at 100 Mbps. It is `SLOW_DIV` times longer (819.2 us by default) when `speed_10m` is high. A separate mode register picks one of two behaviours. In one-shot mode the timer halts at zero. In continuous mode it reloads the last written count and runs again. The mode must be written before the count: the value write samples the mode already held, and later mode writes do not touch a running timer.

The controller is a three-state machine. ST_IDLE means stopped, with the count held. ST_ONESHOT and ST_CONT mean running, in the mode that was captured. The transitions are:
- load: any state goes to ST_ONESHOT or ST_CONT on a nonzero value write, chosen by the held mode.
- stop: any state goes to ST_IDLE on a zero value write.
- finish: ST_ONESHOT goes to ST_IDLE on the final iteration.
- wrap: ST_CONT stays in ST_CONT on the final iteration and reloads the count.

Top module: `speed_iter_timer`

## Requirements
- R1: After reset, `remain` is 0, `expire_pulse` is 0 and the timer is stopped.
- R2: A value write with nonzero data makes `remain` equal that data on the next cycle and starts the timer. The iteration prescaler restarts at that write, so the first iteration is full length.
- R3: With `speed_10m`=0, one iteration is 2^`PRESCALE_W` cycles in which `mii_ce` is high. Enables that arrive on the write cycle are not counted.
- R4: With `speed_10m`=1, one iteration is `SLOW_DIV`×2^`PRESCALE_W` enabled cycles.
- R5: While running, `remain` drops by exactly one at the end of each iteration and is otherwise unchanged.
- R6: At the end of the iteration that takes the count from 1 to 0, `expire_pulse` is high for exactly one cycle, in the same cycle `remain` shows the new value. It is low in every other cycle.
- R7: In one-shot mode (mode bit 0), `remain` stays at 0 after expiry and no further pulse occurs until the next value write.
- R8: In continuous mode (mode bit 1), the final iteration loads `remain` with the last written value instead of 0, and a pulse follows every N iterations.
- R9: A value write uses the mode held before that cycle, including when a mode write happens in the same cycle. Mode writes made while the timer runs do not change its behaviour.
- R10: A value write of zero stops the timer, sets `remain` to 0 and never produces an expiry pulse.
- R11: A value write while the timer runs restarts it with the new count and a fresh prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_10m | input | 1 | 1 = 10 Mbps link (10× longer iterations), 0 = 100 Mbps |
| mii_ce | input | 1 | One-cycle enable at the fast-link nibble-clock rate |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_cont | input | 1 | Mode data: 1 continuous, 0 one-shot |
| value_wr | input | 1 | Write strobe for the iteration count (starts or stops the timer) |
| value_data | input | COUNT_W | Iteration count to load |
| expire_pulse | output | 1 | One-cycle pulse when the count runs out |
| remain | output | COUNT_W | Live remaining iteration count |

## Verification
The in-RTL assertions check the following on every cycle:
- the load, stop, hold and decrement steps of the count;
- the one-shot finish and continuous wrap transitions;
- that an iteration tick only comes with an enable and never on two cycles in a row;
- that a pulse never lasts two cycles.

The bench scenarios check what those local properties cannot show. They confirm the absolute iteration length at both speeds under random enable gaps, and that the first iteration after a write or rewrite is full length. They also confirm that a mode write in the same cycle as a value write, or during a run, leaves the captured mode in force.

// File: rtl/speed_iter_timer_pkg.sv
package speed_iter_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ONESHOT = 2'd1,
        ST_CONT    = 2'd2
    } timer_state_e;

endpackage

// File: rtl/iter_prescaler.sv
module iter_prescaler #(
    parameter int PRESCALE_W = 11,
    parameter int SLOW_DIV   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic speed_10m,
    input  logic mii_ce,
    output logic tick
);
    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PRESCALE_W-1:0] PRE_LAST = '1;

    logic                  step;
    logic [PRESCALE_W-1:0] pre_q;

    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (clear || !run || !speed_10m) begin
                    div_q <= '0;
                end else if (mii_ce) begin
                    div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
                end
            end

            assign step = mii_ce && (!speed_10m || (div_q == DIV_LAST));

            // R4: at low speed an iteration tick only lands on the last slot of the divider
            assert_slow_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && speed_10m) |-> (div_q == DIV_LAST));
        end else begin : g_nodiv
            assign step = mii_ce;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || !run) begin
            pre_q <= '0;
        end else if (step) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && !clear && step && (pre_q == PRE_LAST);

    assert_tick_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (mii_ce && run));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/iter_ctrl.sv
module iter_ctrl
    import speed_iter_timer_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               value_wr,
    input  logic [COUNT_W-1:0] value_data,
    input  logic               mode_cont,
    input  logic               tick,
    output logic               running,
    output logic               expire,
    output logic [COUNT_W-1:0] count
);
    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    timer_state_e       state_q, state_d;
    logic [COUNT_W-1:0] reload_q;
    logic               write_zero;
    logic               last_tick;

    assign write_zero = (value_data == '0);
    assign last_tick  = tick && (count == ONE);
    assign running    = (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (value_wr) begin
            if (write_zero)     state_d = ST_IDLE;
            else if (mode_cont) state_d = ST_CONT;
            else                state_d = ST_ONESHOT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ONESHOT: if (last_tick) state_d = ST_IDLE;
                ST_CONT:    state_d = ST_CONT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: count, reload value, expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            reload_q <= '0;
            expire   <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (value_wr) begin
                count    <= value_data;
                reload_q <= value_data;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ONESHOT: begin
                        if (tick) begin
                            count  <= count - 1'b1;
                            expire <= last_tick;
                        end
                    end
                    ST_CONT: begin
                        if (tick) begin
                            count  <= last_tick ? reload_q : count - 1'b1;
                            expire <= last_tick;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (value_wr && !write_zero) |=> (count == $past(value_data)) && running && !expire);

    assert_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (value_wr && write_zero) |=> (count == '0) && !running && !expire);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !value_wr && !tick) |=> $stable(count) && !expire);

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !value_wr && tick && (count > ONE)) |=> (count == $past(count) - 1'b1) && !expire);

    assert_oneshot_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ONESHOT) && !value_wr && last_tick) |=> (count == '0) && expire && (state_q == ST_IDLE));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !value_wr) |=> $stable(count) && (state_q == ST_IDLE));

    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONT) && !value_wr && last_tick) |=> (count == reload_q) && expire && (state_q == ST_CONT));

endmodule

// File: rtl/speed_iter_timer.sv
module speed_iter_timer #(
    parameter int COUNT_W    = 16,
    parameter int PRESCALE_W = 11,
    parameter int SLOW_DIV   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               speed_10m,
    input  logic               mii_ce,
    input  logic               mode_wr,
    input  logic               mode_cont,
    input  logic               value_wr,
    input  logic [COUNT_W-1:0] value_data,
    output logic               expire_pulse,
    output logic [COUNT_W-1:0] remain
);
    logic mode_q;
    logic tick;
    logic running;

    // mode bit is held here; a value write samples the value held before its own cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (mode_wr) mode_q <= mode_cont;
    end

    iter_prescaler #(
        .PRESCALE_W (PRESCALE_W),
        .SLOW_DIV   (SLOW_DIV)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (value_wr),
        .run       (running),
        .speed_10m (speed_10m),
        .mii_ce    (mii_ce),
        .tick      (tick)
    );

    iter_ctrl #(
        .COUNT_W (COUNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .value_wr   (value_wr),
        .value_data (value_data),
        .mode_cont  (mode_q),
        .tick       (tick),
        .running    (running),
        .expire     (expire_pulse),
        .count      (remain)
    );

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);

    assert_pulse_at_zero_or_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (value_wr && !mode_q && (value_data != '0)) |=> !expire_pulse);

endmodule

// File: tb/speed_iter_timer_bench.sv
module speed_iter_timer_bench;
    localparam int CW        = 16;
    localparam int PW        = 4;
    localparam int DIV       = 10;
    localparam int ITER_FAST = 1 << PW;
    localparam int ITER_SLOW = ITER_FAST * DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          speed_10m = 1'b0;
    logic          mii_ce = 1'b0;
    logic          mode_wr = 1'b0;
    logic          mode_cont = 1'b0;
    logic          value_wr = 1'b0;
    logic [CW-1:0] value_data = '0;
    logic          expire_pulse;
    logic [CW-1:0] remain;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  bench_mode = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    speed_iter_timer #(
        .COUNT_W    (CW),
        .PRESCALE_W (PW),
        .SLOW_DIV   (DIV)
    ) u_speed_iter_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .speed_10m    (speed_10m),
        .mii_ce       (mii_ce),
        .mode_wr      (mode_wr),
        .mode_cont    (mode_cont),
        .value_wr     (value_wr),
        .value_data   (value_data),
        .expire_pulse (expire_pulse),
        .remain       (remain)
    );

    function automatic int exp_remain(int n, bit cont, int c, int iter);
        int k;
        if (n == 0) return 0;
        k = c / iter;
        if (cont) return n - (k % n);
        return (k >= n) ? 0 : n - k;
    endfunction

    function automatic int exp_pulse(int n, bit cont, int c, int iter, bit last_ce);
        int k;
        if (n == 0 || !last_ce || c == 0 || (c % iter) != 0) return 0;
        k = c / iter;
        if (cont) return ((k % n) == 0) ? 1 : 0;
        return (k == n) ? 1 : 0;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        mii_ce    = 1'b0;
        mode_wr   = 1'b1;
        mode_cont = m;
        @(negedge clk);
        mode_wr    = 1'b0;
        bench_mode = m;
    endtask

    // value write; returns the mode the timer is expected to run in
    task automatic start(int n, bit with_mode, bit m, output bit run_cont);
        @(negedge clk);
        value_wr   = 1'b1;
        value_data = CW'(n);
        mii_ce     = ($urandom_range(0, 1) != 0);  // ignored on the write cycle (R3)
        if (with_mode) begin
            mode_wr   = 1'b1;
            mode_cont = m;
        end
        run_cont = bench_mode;
        if (with_mode) bench_mode = m;
        @(posedge clk);
    endtask

    task automatic observe(int n, bit cont, int iter, int total_ce, string tag, bit flip);
        int c = 0;
        bit last = 1'b0;
        bit first = 1'b1;
        while (c < total_ce) begin
            @(negedge clk);
            value_wr = 1'b0;
            mode_wr  = 1'b0;
            check(tag, "remain", int'(remain), exp_remain(n, cont, c, iter));
            check("R6", "expire", int'(expire_pulse), exp_pulse(n, cont, c, iter, last));
            if (flip && first) begin
                mode_wr    = 1'b1;
                mode_cont  = !cont;
                bench_mode = !cont;
            end
            first  = 1'b0;
            mii_ce = ($urandom_range(0, 3) != 0);
            @(posedge clk);
            last = mii_ce;
            if (mii_ce) c++;
        end
        @(negedge clk);
        value_wr = 1'b0;
        mode_wr  = 1'b0;
        mii_ce   = 1'b0;
        check(tag, "remain", int'(remain), exp_remain(n, cont, c, iter));
        check("R6", "expire", int'(expire_pulse), exp_pulse(n, cont, c, iter, last));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit rc;
        void'($urandom(32'd24681));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "remain in reset", int'(remain), 0);
        check("R1", "expire in reset", int'(expire_pulse), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        mii_ce = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "remain after reset", int'(remain), 0);
        check("R1", "expire after reset", int'(expire_pulse), 0);
        mii_ce = 1'b0;

        // R3/R7: fast one-shot, one iteration, then stays at zero
        speed_10m = 1'b0;
        set_mode(1'b0);
        start(1, 1'b0, 1'b0, rc);
        observe(1, rc, ITER_FAST, 3 * ITER_FAST, "R3/R7", 1'b0);

        // R4/R7: slow one-shot
        speed_10m = 1'b1;
        start(2, 1'b0, 1'b0, rc);
        observe(2, rc, ITER_SLOW, 3 * ITER_SLOW, "R4/R7", 1'b0);

        // R8: continuous, three periods
        speed_10m = 1'b0;
        set_mode(1'b1);
        start(3, 1'b0, 1'b0, rc);
        observe(3, rc, ITER_FAST, 9 * ITER_FAST + 5, "R8", 1'b0);

        // R8: continuous with count 1 pulses every iteration
        start(1, 1'b0, 1'b0, rc);
        observe(1, rc, ITER_FAST, 5 * ITER_FAST, "R8", 1'b0);

        // R2: full-width load is read back and decrements
        set_mode(1'b0);
        start(16'hFFFF, 1'b0, 1'b0, rc);
        observe(16'hFFFF, rc, ITER_FAST, 3 * ITER_FAST + 2, "R2", 1'b0);

        // R10: zero write mid-run stops without a pulse
        start(4, 1'b0, 1'b0, rc);
        observe(4, rc, ITER_FAST, ITER_FAST + 4, "R10", 1'b0);
        start(0, 1'b0, 1'b0, rc);
        observe(0, rc, ITER_FAST, 6 * ITER_FAST, "R10", 1'b0);

        // R11: rewrite mid-iteration restarts with a fresh prescaler
        set_mode(1'b1);
        start(5, 1'b0, 1'b0, rc);
        observe(5, rc, ITER_FAST, 2 * ITER_FAST + 7, "R11", 1'b0);
        start(2, 1'b0, 1'b0, rc);
        observe(2, rc, ITER_FAST, 5 * ITER_FAST, "R11", 1'b0);

        // R9: same-cycle mode write does not affect this value write
        start(2, 1'b1, 1'b0, rc);  // held mode is continuous
        check("R9", "captured mode", int'(rc), 1);
        observe(2, rc, ITER_FAST, 5 * ITER_FAST, "R9", 1'b0);
        // R9: held mode now one-shot; mode flipped during run is ignored
        start(2, 1'b0, 1'b0, rc);
        check("R9", "captured mode", int'(rc), 0);
        observe(2, rc, ITER_FAST, 4 * ITER_FAST, "R9", 1'b1);

        // R5: random runs
        for (int i = 0; i < 12; i++) begin
            int  n    = $urandom_range(1, 4);
            bit  m    = $urandom_range(0, 1);
            bit  slow = ($urandom_range(0, 3) == 0);
            int  iter = slow ? ITER_SLOW : ITER_FAST;
            int  tot;
            speed_10m = slow;
            set_mode(m);
            start(n, 1'b0, 1'b0, rc);
            tot = rc ? (2 * n + 1) * iter + 3 : (n + 1) * iter + 5;
            observe(n, rc, iter, tot, "R5", 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule